// File: doc/BRIEF.md
# Buffered Output-Compare Channel Pair

This block joins two timer compare channels into a single glitch-free output-compare channel. A free-running 16-bit counter runs from zero up to a programmable limit, wraps, and flags the wrap as an overflow. Each channel holds a compare value, a two-bit output action and a match flag. When the two channels are not joined, each one drives its own pin from its own compare register.

When the join bit in the first channel's control register is set, the first pin becomes the only compare output. The two compare registers take turns controlling it. The value in use is reloaded only at a counter overflow, and it is taken from whichever compare register software wrote most recently. Software can therefore load the next value into the idle register at any point in a period, and the pin never sees a value that is only half in place.

While the channels are joined, the second channel's control register is ignored. The second pin is handed over to a general-purpose data input.

Top module: `bocp_pair`

## Requirements
- R1: After reset the count is 0 and the limit is 0xFFFF. Each clock the count goes up by one. In a cycle where the count is greater than or equal to the limit, the next count is 0 instead. The overflow output is high for exactly the cycle in which the count reads 0 after such a wrap.
- R2: Write addresses are fixed as follows. 0 is the counter limit. 1 is compare register A. 2 is compare register B. 3 is control A: bit 0 is the join bit, bits 2:1 are the action, and writing 1 to bit 7 clears flag A. 4 is control B: bits 2:1 are the action, and writing 1 to bit 7 clears flag B.
- R3: The action codes are 00 no change, 01 toggle, 10 drive low and 11 drive high. The action is applied to the pin on the clock edge that ends a cycle in which the count equals the compare value in use.
- R4: With the join bit clear, channel A compares against compare register A directly and channel B compares against compare register B directly. Each channel uses its own action and its own flag.
- R5: When the join bit goes from 0 to 1, the compare value in use is loaded from compare register A. Register A is then treated as the one written last.
- R6: While joined, a write to either compare register does not change the compare value in use before the next overflow.
- R7: At each overflow while joined, the compare value in use is loaded from the compare register written most recently. A write in the overflow cycle itself counts, and a later write to the same register replaces an earlier one.
- R8: Flag A sets on the edge after a match of channel A, using the compare value in use. A write to control A with bit 7 set clears flag A, but a match in the same cycle wins.
- R9: While joined, writes to control B are ignored, channel B never matches, and flag B holds its value.
- R10: While joined, the second pin shows the general-purpose data input one cycle later and the released output is high. After the join bit is cleared, the second pin again follows channel B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| gpio_b_dout | input | 1 | General-purpose value for the second pin while joined |
| tmr_count | output | 16 | Current counter value |
| tmr_ovf | output | 1 | One-cycle overflow indication |
| pin_a | output | 1 | Compare output of channel A, and of the joined channel |
| pin_b | output | 1 | Second pin: channel B output, or the general-purpose value while joined |
| pin_b_gpio | output | 1 | High while the second pin is released to general-purpose use |
| flag_a | output | 1 | Match flag of channel A |
| flag_b | output | 1 | Match flag of channel B |

## Verification
Some properties are checked by assertions on every cycle:
- the overflow pulse coincides with a zero count;
- while joined, the compare value in use holds steady between overflows;
- a match always sets its flag;
- the second pin mirrors the general-purpose input while joined, and flag B stays frozen.

Other behaviour can only be shown by the bench's scenarios, which compare the outputs against a cycle-level reference model:
- which register wins at an overflow, including a write landing in the overflow cycle itself;
- that the value taken at the moment of joining is correct;
- that the action codes act correctly on the pin;
- that the pins return to independent operation after the join bit is cleared.

// File: rtl/bocp_pkg.sv
package bocp_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } act_e;

  localparam int unsigned ADR_LIMIT = 0;
  localparam int unsigned ADR_CMP_A = 1;
  localparam int unsigned ADR_CMP_B = 2;
  localparam int unsigned ADR_CTL_A = 3;
  localparam int unsigned ADR_CTL_B = 4;

  localparam int unsigned BIT_JOIN  = 0;
  localparam int unsigned BIT_ACT_L = 1;
  localparam int unsigned BIT_CLR   = 7;

  function automatic logic act_apply(input logic cur, input act_e a);
    case (a)
      ACT_TOGGLE: return ~cur;
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/bocp_counter.sv
module bocp_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] cnt_q,
  output logic          ovf_q,
  output logic          wrap
);

  assign wrap = (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      ovf_q <= wrap;
    end
  end

  // R1: the overflow pulse only ever accompanies a zero count
  p_ovf_zero_r1: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> (cnt_q == '0));

endmodule

// File: rtl/bocp_buffer.sv
module bocp_buffer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          joined,
  input  logic          join_rise,
  input  logic          wr_cmp_a,
  input  logic          wr_cmp_b,
  input  logic [CW-1:0] cmp_a_q,
  input  logic [CW-1:0] cmp_a_nxt,
  input  logic [CW-1:0] cmp_b_nxt,
  input  logic          wrap,
  output logic [CW-1:0] work_q
);

  logic last_b_q;
  logic last_b_nxt;

  always_comb begin
    last_b_nxt = last_b_q;
    if (wr_cmp_b)      last_b_nxt = 1'b1;
    else if (wr_cmp_a) last_b_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_b_q <= 1'b0;
      work_q   <= '0;
    end else if (join_rise) begin
      last_b_q <= 1'b0;
      work_q   <= cmp_a_q;
    end else if (joined) begin
      last_b_q <= last_b_nxt;
      if (wrap) work_q <= last_b_nxt ? cmp_b_nxt : cmp_a_nxt;
    end
  end

  // R6: while joined, the value in use only moves at an overflow
  p_hold_between_ovf_r6: assert property (@(posedge clk) disable iff (rst)
    (joined && !wrap) |=> $stable(work_q));

endmodule

// File: rtl/bocp_channel.sv
module bocp_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cmp,
  input  logic [1:0]    act,
  input  logic          flag_clr,
  output logic          out_q,
  output logic          out_nxt,
  output logic          flag_q
);
  import bocp_pkg::*;

  logic hit;

  assign hit     = en && (cnt == cmp);
  assign out_nxt = hit ? act_apply(out_q, act_e'(act)) : out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      out_q  <= out_nxt;
      flag_q <= hit | (flag_q & ~flag_clr);
    end
  end

  // R8: a match leaves the flag set, whatever software wrote
  p_flag_on_match_r8: assert property (@(posedge clk) disable iff (rst)
    (en && cnt == cmp) |=> flag_q);

endmodule

// File: rtl/bocp_pair.sv
module bocp_pair #(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          gpio_b_dout,
  output logic [CW-1:0] tmr_count,
  output logic          tmr_ovf,
  output logic          pin_a,
  output logic          pin_b,
  output logic          pin_b_gpio,
  output logic          flag_a,
  output logic          flag_b
);
  import bocp_pkg::*;

  localparam int NCH = 2;

  logic [CW-1:0] limit_q, cmp_a_q, cmp_b_q, cmp_a_nxt, cmp_b_nxt, work_q;
  logic          join_q;
  logic [1:0]    act_a_q, act_b_q;
  logic          wr_lim, wr_ca, wr_cb, wr_ta, wr_tb, join_rise, wrap;
  logic          pin_b_q;

  logic [CW-1:0] ch_cmp [NCH];
  logic [1:0]    ch_act [NCH];
  logic [NCH-1:0] ch_en, ch_clr, ch_out, ch_nxt, ch_flag;

  assign wr_lim = wr_en && (wr_addr == AW'(ADR_LIMIT));
  assign wr_ca  = wr_en && (wr_addr == AW'(ADR_CMP_A));
  assign wr_cb  = wr_en && (wr_addr == AW'(ADR_CMP_B));
  assign wr_ta  = wr_en && (wr_addr == AW'(ADR_CTL_A));
  assign wr_tb  = wr_en && (wr_addr == AW'(ADR_CTL_B)) && !join_q;

  assign cmp_a_nxt = wr_ca ? wr_data : cmp_a_q;
  assign cmp_b_nxt = wr_cb ? wr_data : cmp_b_q;
  assign join_rise = wr_ta && wr_data[BIT_JOIN] && !join_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= '1;
      cmp_a_q <= '0;
      cmp_b_q <= '0;
      join_q  <= 1'b0;
      act_a_q <= 2'b00;
      act_b_q <= 2'b00;
    end else begin
      cmp_a_q <= cmp_a_nxt;
      cmp_b_q <= cmp_b_nxt;
      if (wr_lim) limit_q <= wr_data;
      if (wr_ta) begin
        join_q  <= wr_data[BIT_JOIN];
        act_a_q <= wr_data[BIT_ACT_L +: 2];
      end
      if (wr_tb) act_b_q <= wr_data[BIT_ACT_L +: 2];
    end
  end

  bocp_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .limit(limit_q),
    .cnt_q(tmr_count), .ovf_q(tmr_ovf), .wrap(wrap)
  );

  bocp_buffer #(.CW(CW)) u_buf (
    .clk(clk), .rst(rst), .joined(join_q), .join_rise(join_rise),
    .wr_cmp_a(wr_ca), .wr_cmp_b(wr_cb), .cmp_a_q(cmp_a_q),
    .cmp_a_nxt(cmp_a_nxt), .cmp_b_nxt(cmp_b_nxt), .wrap(wrap),
    .work_q(work_q)
  );

  assign ch_cmp[0] = join_q ? work_q : cmp_a_q;
  assign ch_cmp[1] = cmp_b_q;
  assign ch_act[0] = act_a_q;
  assign ch_act[1] = act_b_q;
  assign ch_en     = {!join_q, 1'b1};
  assign ch_clr    = {wr_tb && wr_data[BIT_CLR], wr_ta && wr_data[BIT_CLR]};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    bocp_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst(rst), .en(ch_en[g]), .cnt(tmr_count),
      .cmp(ch_cmp[g]), .act(ch_act[g]), .flag_clr(ch_clr[g]),
      .out_q(ch_out[g]), .out_nxt(ch_nxt[g]), .flag_q(ch_flag[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) pin_b_q <= 1'b0;
    else     pin_b_q <= join_q ? gpio_b_dout : ch_nxt[1];
  end

  assign pin_a      = ch_out[0];
  assign pin_b      = pin_b_q;
  assign pin_b_gpio = join_q;
  assign flag_a     = ch_flag[0];
  assign flag_b     = ch_flag[1];

  // R10: a released second pin follows the general-purpose input
  p_pinb_gpio_r10: assert property (@(posedge clk) disable iff (rst)
    join_q |=> (pin_b == $past(gpio_b_dout)));

  // R9: while joined nothing can move flag B
  p_flagb_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    join_q |=> (flag_b == $past(flag_b)));

endmodule

// File: tb/bocp_pair_bench.sv
module bocp_pair_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        gpio = 1'b0;
  logic [15:0] tmr_count;
  logic        tmr_ovf, pin_a, pin_b, pin_b_gpio, flag_a, flag_b;

  always #10 clk = ~clk;

  bocp_pair u_bocp_pair (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gpio_b_dout(gpio), .tmr_count(tmr_count), .tmr_ovf(tmr_ovf),
    .pin_a(pin_a), .pin_b(pin_b), .pin_b_gpio(pin_b_gpio),
    .flag_a(flag_a), .flag_b(flag_b)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string scen  = "R1";

  // reference model state, updated from the requirements
  logic [15:0] m_cnt, m_lim, m_ca, m_cb, m_work;
  logic        m_ovf, m_join, m_last_b, m_pa, m_pbch, m_pb, m_fa, m_fb;
  logic [1:0]  m_acta, m_actb;

  function automatic logic f_act(input logic cur, input logic [1:0] code);
    if (code == 2'b01) return !cur;
    if (code == 2'b10) return 1'b0;
    if (code == 2'b11) return 1'b1;
    return cur;
  endfunction

  always @(posedge clk) begin : model
    logic        wrap, ma, mb, lastn, pa_n, pb_n;
    logic        w0, w1, w2, w3, w4;
    logic [15:0] ca_n, cb_n;
    if (rst) begin
      m_cnt <= 0; m_lim <= 16'hFFFF; m_ca <= 0; m_cb <= 0; m_work <= 0;
      m_ovf <= 0; m_join <= 0; m_last_b <= 0; m_pa <= 0; m_pbch <= 0;
      m_pb <= 0; m_fa <= 0; m_fb <= 0; m_acta <= 0; m_actb <= 0;
    end else begin
      w0 = wr_en && wr_addr == 0; w1 = wr_en && wr_addr == 1;
      w2 = wr_en && wr_addr == 2; w3 = wr_en && wr_addr == 3;
      w4 = wr_en && wr_addr == 4;
      wrap = (m_cnt >= m_lim);
      ca_n = w1 ? wr_data : m_ca;
      cb_n = w2 ? wr_data : m_cb;
      ma = m_join ? (m_cnt == m_work) : (m_cnt == m_ca);
      mb = !m_join && (m_cnt == m_cb);
      pa_n = ma ? f_act(m_pa, m_acta) : m_pa;
      pb_n = mb ? f_act(m_pbch, m_actb) : m_pbch;
      m_pa   <= pa_n;
      m_pbch <= pb_n;
      m_pb   <= m_join ? gpio : pb_n;
      m_fa   <= ma | (m_fa & !(w3 && wr_data[7]));
      m_fb   <= mb | (m_fb & !(w4 && wr_data[7] && !m_join));
      m_cnt  <= wrap ? 16'd0 : m_cnt + 16'd1;
      m_ovf  <= wrap;
      m_ca   <= ca_n;
      m_cb   <= cb_n;
      if (w0) m_lim <= wr_data;
      if (w3) begin m_join <= wr_data[0]; m_acta <= wr_data[2:1]; end
      if (w4 && !m_join) m_actb <= wr_data[2:1];
      if (w3 && wr_data[0] && !m_join) begin
        m_last_b <= 0; m_work <= m_ca;
      end else if (m_join) begin
        lastn = w2 ? 1'b1 : (w1 ? 1'b0 : m_last_b);
        m_last_b <= lastn;
        if (wrap) m_work <= lastn ? cb_n : ca_n;
      end
    end
  end

  task automatic check(input string req, input string sig,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s [scenario %s]: actual %0h expected %0h",
               req, sig, scen, act, exp);
    end
  endtask

  task automatic cmp_all;
    check("R1", "count", tmr_count, m_cnt);
    check("R1", "overflow", {15'd0, tmr_ovf}, {15'd0, m_ovf});
    check("R3", "pin_a", {15'd0, pin_a}, {15'd0, m_pa});
    check("R8", "flag_a", {15'd0, flag_a}, {15'd0, m_fa});
    check("R9", "flag_b", {15'd0, flag_b}, {15'd0, m_fb});
    check("R10", "pin_b", {15'd0, pin_b}, {15'd0, m_pb});
    check("R10", "released", {15'd0, pin_b_gpio}, {15'd0, m_join});
  endtask

  task automatic tick(input logic we, input logic [2:0] a, input logic [15:0] d);
    wr_en = we; wr_addr = a; wr_data = d;
    @(negedge clk);
    cmp_all();
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 3'd0, 16'd0);
  endtask

  task automatic to_wrap_cycle(input logic [15:0] lim);
    while (tmr_count != lim) tick(1'b0, 3'd0, 16'd0);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(64'd20 * 64'd200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset count", tmr_count, 16'd0);
    check("R1", "reset pin_a", {15'd0, pin_a}, 16'd0);
    check("R8", "reset flag_a", {15'd0, flag_a}, 16'd0);
    check("R9", "reset flag_b", {15'd0, flag_b}, 16'd0);
    rst = 1'b0;

    scen = "R2";
    tick(1, 3'd0, 16'd23);
    tick(1, 3'd1, 16'd5);
    tick(1, 3'd2, 16'd9);
    tick(1, 3'd3, 16'h0002);        // toggle, not joined
    tick(1, 3'd4, 16'h0006);        // drive high
    scen = "R4";
    idle(60);
    tick(1, 3'd4, 16'h0084);        // clear flag B, drive low
    tick(1, 3'd3, 16'h0086);        // clear flag A, drive high
    idle(30);

    scen = "R5";
    tick(1, 3'd3, 16'h0003);        // join, toggle
    idle(30);
    scen = "R6";
    to_wrap_cycle(16'd23);
    idle(2);
    tick(1, 3'd2, 16'd15);
    idle(40);
    scen = "R7";
    tick(1, 3'd1, 16'd3);
    tick(1, 3'd2, 16'd11);
    tick(1, 3'd2, 16'd19);
    idle(30);
    to_wrap_cycle(16'd23);
    tick(1, 3'd1, 16'd7);           // write in the overflow cycle
    idle(30);
    scen = "R8";
    tick(1, 3'd3, 16'h0083);
    idle(25);
    scen = "R9";
    tick(1, 3'd4, 16'h0086);
    gpio = 1'b1; idle(3); gpio = 1'b0; idle(3);
    scen = "R10";
    tick(1, 3'd3, 16'h0002);        // leave joined mode
    idle(50);

    scen = "random";
    for (int i = 0; i < 3000; i++) begin
      logic [2:0]  a;
      logic [15:0] d;
      gpio = 1'($urandom);
      if ($urandom % 6 == 0) begin
        a = 3'($urandom % 5);
        case (a)
          3'd0:    d = 16'(8 + $urandom % 33);
          3'd1,
          3'd2:    d = 16'($urandom % 48);
          3'd3:    d = {8'd0, 1'($urandom), 4'd0, 2'($urandom),
                        1'($urandom % 4 != 0)};
          default: d = 16'($urandom);
        endcase
        tick(1'b1, a, d);
      end else begin
        tick(1'b0, 3'd0, 16'd0);
      end
    end
    summary();
  end

endmodule